// File: doc/BRIEF.md
# Interrupt Shadow Context Controller

This block holds a small set of architectural registers (general registers and one status register) and keeps a copy of them for interrupt handling. When an interrupt is taken for a fast cause, the whole set is copied into shadow storage in the same clock edge. A fast return copies it all back in one edge. For the non-maskable cause only the status register is copied, into its own save slot. The matching return brings back only that status value.

The two save areas are independent, so a non-maskable interrupt taken inside a fast handler leaves the fast shadow untouched. Nesting is not supported: a second fast entry overwrites the fast shadow. Software writes reach the registers through a write port. The full register view is driven out on flat output buses. One-cycle done pulses mark each save and each restore.

Top module: `ctx_shadow_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, every general register, the status register, the fast shadow and the non-maskable save slot become zero, and both done pulses are low.
- R2: When `irq_take` is high and `irq_cause` is 4 to 15 (maskable lines), 16 (software interrupt) or 17 (undefined instruction), every general register and the status register are copied into the fast shadow at that edge, and `save_done` is high for exactly the following cycle.
- R3: When `irq_take` is high and `irq_cause` is 18 (non-maskable), only the status register is copied, into the non-maskable save slot. The fast shadow is left unchanged, and `save_done` is high for the following cycle.
- R4: An `irq_take` whose `irq_cause` is 0 to 3 or 19 to 31 saves nothing and gives no `save_done` pulse.
- R5: A `ret_fast` strobe loads every general register and the status register from the fast shadow in one edge, and `restore_done` is high for the following cycle. If `ret_nmi` is high in the same cycle, `ret_fast` takes priority.
- R6: A `ret_nmi` strobe alone loads only the status register from the non-maskable save slot. The general registers are unchanged apart from ordinary writes, and `restore_done` is high for the following cycle.
- R7: A restore overrides a write to the same register in the same cycle. Under `ret_fast` all writes that cycle are dropped. Under `ret_nmi` a status write is dropped, but a general register write still lands.
- R8: A second fast entry overwrites the fast shadow with the registers live at that entry.
- R9: A save captures the register values from before the edge. A write in the same cycle lands in the live registers but not in the shadow.
- R10: When an entry with a valid cause is taken in the same cycle as a return strobe, the return is ignored: no registers are loaded from any save area, and `restore_done` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | General register write enable |
| wr_addr | input | 3 | General register index |
| wr_data | input | 32 | General register write data |
| csr_we | input | 1 | Status register write enable |
| csr_wdata | input | 32 | Status register write data |
| irq_take | input | 1 | Interrupt entry strobe |
| irq_cause | input | 5 | Cause code of the entry |
| ret_fast | input | 1 | Return strobe for fast causes |
| ret_nmi | input | 1 | Return strobe for the non-maskable cause |
| gpr_flat | output | 256 | All general registers, register i at bits i*32 and up |
| csr_q | output | 32 | Status register |
| save_done | output | 1 | One-cycle pulse after a save |
| restore_done | output | 1 | One-cycle pulse after a restore |

## Verification
Every result is due exactly one edge after its stimulus. Register contents, shadow effects and both done pulses all change at the edge that samples the strobe. The bench drives inputs on the falling edge, lets one rising edge pass, and compares every output on the next falling edge against a model that it updates from the same stimulus. Effects on the hidden shadows are read back through a later return strobe. The cause sweep covers all 32 codes, and each code is followed by a fast return.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int CAUSE_W     = 5;
  localparam int MASK_LO     = 4;
  localparam int MASK_HI     = 15;
  localparam int CAUSE_SOFT  = 16;
  localparam int CAUSE_UNDEF = 17;
  localparam int CAUSE_NMI   = 18;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_FAST = 2'd1,
    CLS_NMI  = 2'd2
  } ctx_class_e;
endpackage

// File: rtl/ctx_cause_decode.sv
module ctx_cause_decode
  import ctx_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause,
  output ctx_class_e         cls
);
  always_comb begin
    cls = CLS_NONE;
    if ((int'(cause) >= MASK_LO && int'(cause) <= MASK_HI) ||
        int'(cause) == CAUSE_SOFT || int'(cause) == CAUSE_UNDEF)
      cls = CLS_FAST;
    else if (int'(cause) == CAUSE_NMI)
      cls = CLS_NMI;
  end
endmodule

// File: rtl/ctx_shadow_bank.sv
module ctx_shadow_bank #(
  parameter int W = 32,
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         save_fast,
  input  logic         save_nmi,
  input  logic [N*W-1:0] live_gpr,
  input  logic [W-1:0] live_csr,
  output logic [N*W-1:0] sh_gpr,
  output logic [W-1:0] sh_csr,
  output logic [W-1:0] nmi_csr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_gpr  <= '0;
      sh_csr  <= '0;
      nmi_csr <= '0;
    end else begin
      if (save_fast) begin
        sh_gpr <= live_gpr;
        sh_csr <= live_csr;
      end
      if (save_nmi) nmi_csr <= live_csr;
    end
  end

  assert_nmi_keeps_fast_R3: assert property (@(posedge clk) disable iff (rst)
    (save_nmi && !save_fast) |=> (sh_gpr == $past(sh_gpr) && sh_csr == $past(sh_csr)));
  assert_exclusive_save_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({save_fast, save_nmi}));
endmodule

// File: rtl/ctx_arch_regs.sv
module ctx_arch_regs #(
  parameter int W = 32,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         csr_we,
  input  logic [W-1:0] csr_wdata,
  input  logic         ld_all,
  input  logic         ld_csr,
  input  logic [N*W-1:0] sh_gpr,
  input  logic [W-1:0] sh_csr,
  input  logic [W-1:0] nmi_csr,
  output logic [N*W-1:0] gpr_flat,
  output logic [W-1:0] csr_q
);
  logic [W-1:0] rf [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) rf[i] <= '0;
      csr_q <= '0;
    end else if (ld_all) begin
      for (int i = 0; i < N; i++) rf[i] <= sh_gpr[i*W +: W];
      csr_q <= sh_csr;
    end else begin
      if (wr_en) rf[wr_addr] <= wr_data;
      if (ld_csr) csr_q <= nmi_csr;
      else if (csr_we) csr_q <= csr_wdata;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign gpr_flat[g*W +: W] = rf[g];
  end

  assert_nmi_ret_csr_R6: assert property (@(posedge clk) disable iff (rst)
    (ld_csr && !ld_all) |=> csr_q == $past(nmi_csr));
endmodule

// File: rtl/ctx_shadow_ctrl.sv
module ctx_shadow_ctrl
  import ctx_pkg::*;
#(
  parameter int W = 32,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic           csr_we,
  input  logic [W-1:0]   csr_wdata,
  input  logic           irq_take,
  input  logic [CAUSE_W-1:0] irq_cause,
  input  logic           ret_fast,
  input  logic           ret_nmi,
  output logic [N*W-1:0] gpr_flat,
  output logic [W-1:0]   csr_q,
  output logic           save_done,
  output logic           restore_done
);
  ctx_class_e cls;
  logic entry_ok, save_fast, save_nmi, ld_all, ld_csr;
  logic [N*W-1:0] sh_gpr;
  logic [W-1:0] sh_csr, nmi_csr;

  ctx_cause_decode u_dec (.cause(irq_cause), .cls(cls));

  assign save_fast = irq_take && (cls == CLS_FAST);
  assign save_nmi  = irq_take && (cls == CLS_NMI);
  assign entry_ok  = save_fast || save_nmi;
  assign ld_all    = ret_fast && !entry_ok;
  assign ld_csr    = ret_nmi && !ret_fast && !entry_ok;

  ctx_shadow_bank #(.W(W), .N(N)) u_bank (
    .clk(clk), .rst(rst), .save_fast(save_fast), .save_nmi(save_nmi),
    .live_gpr(gpr_flat), .live_csr(csr_q),
    .sh_gpr(sh_gpr), .sh_csr(sh_csr), .nmi_csr(nmi_csr)
  );

  ctx_arch_regs #(.W(W), .N(N)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .ld_all(ld_all), .ld_csr(ld_csr),
    .sh_gpr(sh_gpr), .sh_csr(sh_csr), .nmi_csr(nmi_csr),
    .gpr_flat(gpr_flat), .csr_q(csr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      save_done    <= 1'b0;
      restore_done <= 1'b0;
    end else begin
      save_done    <= entry_ok;
      restore_done <= ld_all || ld_csr;
    end
  end

  assert_save_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (irq_take && (cls != CLS_NONE)) |=> save_done);
  assert_ignored_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (!irq_take || cls == CLS_NONE) |=> !save_done);
  assert_fast_restore_R5: assert property (@(posedge clk) disable iff (rst)
    (ret_fast && !irq_take) |=> (restore_done && csr_q == $past(sh_csr) && gpr_flat == $past(sh_gpr)));
  assert_restore_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (ret_fast && wr_en && !irq_take) |=> gpr_flat == $past(sh_gpr));
  assert_entry_blocks_ret_R10: assert property (@(posedge clk) disable iff (rst)
    (entry_ok && (ret_fast || ret_nmi)) |=> !restore_done);
endmodule

// File: tb/ctx_shadow_ctrl_test.sv
module ctx_shadow_ctrl_test;
  localparam int W = 32;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, csr_we = 0, irq_take = 0, ret_fast = 0, ret_nmi = 0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0, csr_wdata = '0;
  logic [4:0] irq_cause = '0;
  logic [N*W-1:0] gpr_flat;
  logic [W-1:0] csr_q;
  logic save_done, restore_done;

  int tests = 0, fails = 0, cycles = 0;

  logic [W-1:0] m_g [N];
  logic [W-1:0] m_sg [N];
  logic [W-1:0] m_csr, m_scsr, m_ncsr;
  logic m_sd, m_rd;

  always #5 clk = ~clk;

  ctx_shadow_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .irq_take(irq_take), .irq_cause(irq_cause),
    .ret_fast(ret_fast), .ret_nmi(ret_nmi), .gpr_flat(gpr_flat), .csr_q(csr_q),
    .save_done(save_done), .restore_done(restore_done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < N; i++) chk(tag, $sformatf("gpr%0d", i), gpr_flat[i*W +: W], m_g[i]);
    chk(tag, "csr", csr_q, m_csr);
    chk(tag, "save_done", {31'd0, save_done}, {31'd0, m_sd});
    chk(tag, "restore_done", {31'd0, restore_done}, {31'd0, m_rd});
  endtask

  task automatic step(input string tag, input logic we, input logic [2:0] a, input logic [W-1:0] d,
                      input logic cwe, input logic [W-1:0] cd, input logic tk, input logic [4:0] c,
                      input logic rf, input logic rn);
    logic fast, nmi, ok;
    logic [W-1:0] og [N];
    logic [W-1:0] ocsr;
    wr_en = we; wr_addr = a; wr_data = d; csr_we = cwe; csr_wdata = cd;
    irq_take = tk; irq_cause = c; ret_fast = rf; ret_nmi = rn;
    @(posedge clk);
    fast = tk && ((c >= 5'd4 && c <= 5'd15) || c == 5'd16 || c == 5'd17);
    nmi  = tk && (c == 5'd18);
    ok   = fast || nmi;
    for (int i = 0; i < N; i++) og[i] = m_g[i];
    ocsr = m_csr;
    if (!ok && rf) begin
      for (int i = 0; i < N; i++) m_g[i] = m_sg[i];
      m_csr = m_scsr;
    end else begin
      if (we) m_g[a] = d;
      if (!ok && rn) m_csr = m_ncsr;
      else if (cwe) m_csr = cd;
    end
    if (fast) begin
      for (int i = 0; i < N; i++) m_sg[i] = og[i];
      m_scsr = ocsr;
    end
    if (nmi) m_ncsr = ocsr;
    m_sd = ok;
    m_rd = !ok && (rf || rn);
    @(negedge clk);
    wr_en = 0; csr_we = 0; irq_take = 0; ret_fast = 0; ret_nmi = 0;
    check_all(tag);
  endtask

  task automatic fill(input string tag, input int seed);
    for (int i = 0; i < N; i++)
      step(tag, 1, 3'(i), W'(seed * 32'h0101_0007 + i * 32'h0011_0003), 0, 0, 0, 0, 0, 0);
    step(tag, 0, 0, 0, 1, W'(seed * 32'h0003_0501 + 32'h00A5_0000), 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_g[i] = '0; m_sg[i] = '0; end
    m_csr = '0; m_scsr = '0; m_ncsr = '0; m_sd = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst = 0;

    // R2/R4 sweep over every cause code, each read back by a fast return
    for (int c = 0; c < 32; c++) begin
      fill("R2", c + 1);
      step((c >= 4 && c <= 18) ? "R2" : "R4", 0, 0, 0, 0, 0, 1, 5'(c), 0, 0);
      step("R2", 1, 3'(c % N), 32'hDEAD_0000 + c, 1, 32'hC5C5_0000 + c, 0, 0, 0, 0);
      step("R5", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    end

    // R3/R6: non-maskable inside a fast handler
    fill("R3", 100);
    step("R3", 0, 0, 0, 0, 0, 1, 5'd9, 0, 0);
    step("R3", 0, 0, 0, 1, 32'h1111_2222, 0, 0, 0, 0);
    step("R3", 1, 3'd2, 32'h3333_4444, 0, 0, 1, 5'd18, 0, 0);
    step("R3", 1, 3'd5, 32'h5555_6666, 1, 32'h7777_8888, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R3", 0, 0, 0, 0, 0, 0, 0, 1, 0);

    // R7: restore against same-cycle writes
    fill("R7", 200);
    step("R7", 0, 0, 0, 0, 0, 1, 5'd16, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 1, 5'd18, 0, 0);
    fill("R7", 201);
    step("R7", 1, 3'd3, 32'hABCD_0001, 1, 32'hABCD_0002, 0, 0, 1, 0);
    step("R7", 1, 3'd4, 32'hABCD_0003, 1, 32'hABCD_0004, 0, 0, 0, 1);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 1, 1);

    // R8: second fast entry overwrites
    fill("R8", 300);
    step("R8", 0, 0, 0, 0, 0, 1, 5'd4, 0, 0);
    fill("R8", 301);
    step("R8", 0, 0, 0, 0, 0, 1, 5'd17, 0, 0);
    fill("R8", 302);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 0);

    // R9: save sees pre-edge values while write lands live
    fill("R9", 400);
    step("R9", 1, 3'd1, 32'h0F0F_0F0F, 1, 32'hF0F0_F0F0, 1, 5'd12, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R9", 1, 3'd6, 32'h1234_5678, 1, 32'h8765_4321, 1, 5'd18, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1);

    // R10: entry plus return in one cycle
    fill("R10", 500);
    step("R10", 0, 0, 0, 0, 0, 1, 5'd7, 1, 0);
    step("R10", 0, 0, 0, 0, 0, 1, 5'd18, 0, 1);
    step("R10", 0, 0, 0, 0, 0, 1, 5'd2, 1, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1);

    // R1: reset clears everything, read back through returns
    rst = 1;
    @(posedge clk);
    for (int i = 0; i < N; i++) begin m_g[i] = '0; m_sg[i] = '0; end
    m_csr = '0; m_scsr = '0; m_ncsr = '0; m_sd = 0; m_rd = 0;
    @(negedge clk);
    rst = 0;
    check_all("R1");
    fill("R1", 600);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 1, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule